// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block is the read lookup path of a small two-way set-associative cache for instruction fetch. Each set keeps one prediction bit that names the way expected to hold the next line requested from that set. After a request is accepted, one cycle is spent on the predicted way. The block compares that way's tag and already steers its data to the response bus. If that way does not match, the other way is checked with the same single comparator in the next cycle. If neither way matches, the block asks for a refill and waits on its refill port.

Each response carries a latency class: fast hit, way-miss hit, or miss served by refill. The processor side can use it to schedule fetch. A line is one data word. The low `log2(SETS)` address bits select the set, and the remaining bits form the tag. The path is read-only. Lines only enter through refill. The refill victim is the way that is not currently predicted, and the prediction then moves to the way that holds the requested line.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and fill_req_o are 0, every line is invalid and every set predicts way 0.
- R2: A request is taken on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o is then 0 from the next cycle until the cycle after the response.
- R3: If the predicted way holds the tag, the response arrives in the cycle after acceptance with rsp_hit_o=1, rsp_lat_o=1 and the line's data.
- R4: If only the other way holds the tag, the response arrives two cycles after acceptance with rsp_hit_o=1 and rsp_lat_o=2. The set's prediction then names that way, so the next lookup of the same line is a fast hit.
- R5: If neither way holds the tag, fill_req_o rises three cycles after acceptance with fill_addr_o equal to the request address. Both hold steady until fill_valid_i is seen.
- R6: While fill_req_o is 1, fill_valid_i produces a response in the same cycle with rsp_data_o=fill_data_i, rsp_hit_o=0 and rsp_lat_o=3. The line is written into the way that is not predicted, and the prediction then names that way.
- R7: fill_valid_i has no effect while fill_req_o is 0. No response is given and no line is installed.
- R8: Prediction bits and lines of one set are unaffected by lookups and refills of another set.
- R9: rsp_valid_o is a one-cycle pulse per accepted request. rsp_lat_o is 0 whenever rsp_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_addr_i | input | ADDR_W | Word address to look up |
| req_ready_o | output | 1 | Block can accept a request |
| rsp_valid_o | output | 1 | Response valid pulse |
| rsp_data_o | output | DATA_W | Line data |
| rsp_hit_o | output | 1 | 1 if served from the arrays |
| rsp_lat_o | output | 2 | 1 fast hit, 2 way-miss hit, 3 refill, 0 idle |
| fill_req_o | output | 1 | Refill requested |
| fill_addr_o | output | ADDR_W | Address to refill |
| fill_valid_i | input | 1 | Refill data valid |
| fill_data_i | input | DATA_W | Refill data |

## Verification
The bench runs a set of conflict sequences. Three tags share one set, so it reaches fast hits, way-miss hits and refills that evict a live line. A design that picks the predicted way as victim would throw away the line it just used and report refills where way-miss hits are expected. A design that never flips the prediction would give latency 2 where latency 1 is expected. The bench also delays refills by several cycles to catch a request line or address that does not hold. It sends a stray refill strobe while idle to catch a design that installs it. It counts the latency of each response itself, so a class code that does not match the real cycle count is reported.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_FILL} wpc_state_e;
  localparam logic [1:0] LAT_NONE = 2'd0;
  localparam logic [1:0] LAT_FAST = 2'd1;
  localparam logic [1:0] LAT_WAY  = 2'd2;
  localparam logic [1:0] LAT_MISS = 2'd3;
endpackage

// File: rtl/wpc_way.sv
module wpc_way #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s]  <= '0;
        data_q[s] <= '0;
      end
    end else if (wr_en_i) begin
      valid_q[wr_idx_i] <= 1'b1;
      tag_q[wr_idx_i]   <= wr_tag_i;
      data_q[wr_idx_i]  <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/wpc_pred.sv
module wpc_pred #(
  parameter int SETS = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_way_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_way_o
);
  logic [SETS-1:0] pred_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pred_q <= '0;
    else if (upd_en_i) pred_q[upd_idx_i] <= upd_way_i;
  end

  assign rd_way_o = pred_q[rd_idx_i];
endmodule

// File: rtl/wpc_tag_cmp.sv
module wpc_tag_cmp #(
  parameter int TAG_W = 8
) (
  input  logic             line_valid_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             match_o
);
  assign match_o = line_valid_i && (line_tag_i == look_tag_i);
endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup
  import wpc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int WAYS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_hit_o,
  output logic [1:0]        rsp_lat_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i
);
  wpc_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              pred_way, probe_way, hit, fill_fire, pred_upd;
  logic              way_valid [WAYS];
  logic [TAG_W-1:0]  way_tag   [WAYS];
  logic [DATA_W-1:0] way_data  [WAYS];

  assign idx = addr_q[IDX_W-1:0];
  assign tag = addr_q[ADDR_W-1:IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (req_valid_i && req_ready_o) addr_q <= req_addr_i;
    end
  end

  // second probe looks at the way the prediction skipped
  assign probe_way = (state_q == ST_SECOND) ? ~pred_way : pred_way;
  assign fill_fire = (state_q == ST_FILL) && fill_valid_i;
  // victim on refill and target after way-miss hit are both the unpredicted way
  assign pred_upd  = ((state_q == ST_SECOND) && hit) || fill_fire;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wpc_way #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (fill_fire && (~pred_way == 1'(w))),
      .wr_idx_i   (idx),
      .wr_tag_i   (tag),
      .wr_data_i  (fill_data_i),
      .rd_idx_i   (idx),
      .rd_valid_o (way_valid[w]),
      .rd_tag_o   (way_tag[w]),
      .rd_data_o  (way_data[w])
    );
  end

  wpc_pred #(.SETS(SETS)) i_pred (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (pred_upd),
    .upd_idx_i (idx),
    .upd_way_i (~pred_way),
    .rd_idx_i  (idx),
    .rd_way_o  (pred_way)
  );

  wpc_tag_cmp #(.TAG_W(TAG_W)) i_cmp (
    .line_valid_i (way_valid[probe_way]),
    .line_tag_i   (way_tag[probe_way]),
    .look_tag_i   (tag),
    .match_o      (hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_FIRST;
      ST_FIRST:  state_d = hit ? ST_IDLE : ST_SECOND;
      ST_SECOND: state_d = hit ? ST_IDLE : ST_FILL;
      ST_FILL:   if (fill_valid_i) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rsp_lat_o = LAT_NONE;
    if (fill_fire)                        rsp_lat_o = LAT_MISS;
    else if (hit && state_q == ST_FIRST)  rsp_lat_o = LAT_FAST;
    else if (hit && state_q == ST_SECOND) rsp_lat_o = LAT_WAY;
  end

  assign rsp_valid_o = (rsp_lat_o != LAT_NONE);
  assign rsp_hit_o   = rsp_valid_o && !fill_fire;
  assign rsp_data_o  = fill_fire ? fill_data_i : way_data[probe_way];
  assign req_ready_o = (state_q == ST_IDLE);
  assign fill_req_o  = (state_q == ST_FILL);
  assign fill_addr_o = addr_q;
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic              rsp_hit_o,
  input logic [1:0]        rsp_lat_o,
  input logic              fill_req_o,
  input logic [ADDR_W-1:0] fill_addr_o,
  input logic              fill_valid_i,
  input logic [DATA_W-1:0] fill_data_i
);
  logic accept;
  assign accept = req_valid_i && req_ready_o;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o); // R2
  AST_ADDR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> fill_addr_o == $past(req_addr_i)); // R5
  AST_FILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && !fill_valid_i |=> fill_req_o && $stable(fill_addr_o)); // R5
  AST_FILL_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_o && fill_valid_i |-> rsp_valid_o && !rsp_hit_o && rsp_lat_o == 2'd3
                                   && rsp_data_o == fill_data_i); // R6
  AST_FAST_TIMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_lat_o == 2'd1 |-> $past(accept)); // R3
  AST_HIT_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_hit_o == (rsp_lat_o != 2'd3)); // R3
  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o); // R9
  AST_IDLE_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> rsp_lat_o == 2'd0 && !rsp_hit_o); // R9
  AST_NO_STRAY_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !rsp_valid_o && !fill_req_o); // R7
endmodule

bind wp_cache_lookup wpc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wpc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
  .rsp_hit_o(rsp_hit_o), .rsp_lat_o(rsp_lat_o), .fill_req_o(fill_req_o),
  .fill_addr_o(fill_addr_o), .fill_valid_i(fill_valid_i), .fill_data_i(fill_data_i)
);

// File: tb/test_wp_cache_lookup.sv
`timescale 1ns/1ps
module test_wp_cache_lookup;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NVEC   = 13;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              req_ready_o, rsp_valid_o, rsp_hit_o, fill_req_o;
  logic [DATA_W-1:0] rsp_data_o;
  logic [1:0]        rsp_lat_o;
  logic [ADDR_W-1:0] fill_addr_o;
  logic              fill_valid_i = 1'b0;
  logic [DATA_W-1:0] fill_data_i = '0;

  int checks = 0;
  int errors = 0;
  int fast_hits = 0;
  int all_hits = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  wp_cache_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(4)) i_wp_cache_lookup (.*);

  // {address, expected latency class}; set = addr[1:0], tag = addr[11:2]
  localparam logic [15:0] VEC [NVEC] = '{
    {12'h010, 4'd3}, {12'h010, 4'd1}, {12'h020, 4'd3}, {12'h010, 4'd2},
    {12'h010, 4'd1}, {12'h020, 4'd2}, {12'h030, 4'd3}, {12'h010, 4'd3},
    {12'h030, 4'd2}, {12'h011, 4'd3}, {12'h030, 4'd1}, {12'h011, 4'd1},
    {12'h010, 4'd2}
  };

  function automatic logic [DATA_W-1:0] line_of(logic [ADDR_W-1:0] a);
    return {20'hC0DE0, a};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(int lat);
    return lat == 1 ? "R3" : lat == 2 ? "R4" : "R6";
  endfunction

  task automatic access(logic [ADDR_W-1:0] a, int exp_lat, int fill_wait);
    int cyc = 0;
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R2 ready before request", req_ready_o, 1);
    req_valid_i = 1'b1;
    req_addr_i  = a;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cyc = 1;
    while (!rsp_valid_o && !fill_req_o && cyc < 3) begin
      chk(req_ready_o == 1'b0, "R2 ready low while busy", req_ready_o, 0);
      @(negedge clk_i);
      cyc++;
    end
    if (fill_req_o) begin
      chk(cyc == 3, "R5 refill request timing", cyc, 3);
      chk(fill_addr_o == a, "R5 refill address", fill_addr_o, a);
      for (int k = 0; k < fill_wait; k++) begin
        @(negedge clk_i);
        chk(fill_req_o && fill_addr_o == a && !rsp_valid_o, "R5 refill held", fill_req_o, 1);
      end
      fill_valid_i = 1'b1;
      fill_data_i  = line_of(a);
      #1;
      chk(rsp_valid_o && !rsp_hit_o && rsp_lat_o == 2'd3, "R6 refill response",
          rsp_lat_o, 3);
      chk(rsp_data_o == line_of(a), "R6 refill data", rsp_data_o, line_of(a));
      chk(exp_lat == 3, {req_of(exp_lat), " latency class"}, 3, exp_lat);
      @(negedge clk_i);
      fill_valid_i = 1'b0;
    end else begin
      chk(rsp_valid_o && rsp_hit_o, {req_of(exp_lat), " hit response"}, rsp_valid_o, 1);
      chk(int'(rsp_lat_o) == exp_lat && cyc == exp_lat, {req_of(exp_lat), " latency"},
          rsp_lat_o, exp_lat);
      chk(rsp_data_o == line_of(a), {req_of(exp_lat), " hit data"}, rsp_data_o, line_of(a));
      all_hits++;
      if (rsp_lat_o == 2'd1) fast_hits++;
      @(negedge clk_i);
    end
    chk(!rsp_valid_o && rsp_lat_o == 2'd0 && req_ready_o, "R9 single pulse", rsp_valid_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #12;
    chk(req_ready_o && !rsp_valid_o && !fill_req_o && rsp_lat_o == 2'd0,
        "R1 reset outputs", {req_ready_o, rsp_valid_o, fill_req_o}, 3'b100);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++)
      access(VEC[i][15:4], int'(VEC[i][3:0]), i % 3); // R8 via set 1 lines in vectors 9-11

    // R7: stray refill strobe while idle installs nothing
    @(negedge clk_i);
    fill_valid_i = 1'b1;
    fill_data_i  = 32'hDEADBEEF;
    #1;
    chk(!rsp_valid_o && req_ready_o, "R7 stray strobe no response", rsp_valid_o, 0);
    @(negedge clk_i);
    fill_valid_i = 1'b0;
    access(12'h042, 3, 0); // R7 set 2 still empty
    access(12'h042, 1, 0);
    access(12'h082, 3, 1); // R6 second line of set 2 goes to unpredicted way
    access(12'h042, 2, 0);

    // R1: reset mid-sequence clears lines and predictions
    rst_ni = 1'b0;
    #3;
    chk(req_ready_o && !fill_req_o, "R1 reset again", req_ready_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    access(12'h010, 3, 0); // R1 lines invalid after reset

    $display("prediction accuracy %0d of %0d hits", fast_hits, all_hits);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule